// File: doc/BRIEF.md
# Serially Loaded Auto-Reload Interval Timer

This block is a programmable interval timer that a processor programs one bit at a time over a bit-addressed serial I/O bus. Each bus address selects a single bit. Address 0 switches the block between plain I/O mode and timer mode. In timer mode, fourteen consecutive addresses reach the individual bits of a shadow count register.

Writing the most significant count bit launches the timer with the assembled value. A divide-by-30 prescaler then drives a decrementer. When the count runs out, the decrementer reloads the launched value and sets an interrupt flag. The interrupt reaches its output only while the mask bit allows it. A zero launch value leaves the timer idle.

Software reads the count through a snapshot register. The snapshot is captured whenever timer mode is selected, so that every bit read afterwards belongs to the same count value.

Top module: `serial_interval_timer`

## Requirements
- R1: While `rst` is high, and right after it is released, the block is in I/O mode: the shadow register, the launched value and the count are zero, the mask is 0, and both `irq_o` and `rd_bit_o` are 0.
- R2: Address map. Address 0 is the mode bit: writing 1 selects timer mode and writing 0 selects I/O mode. Address k, for k from 1 to 14, is count bit k-1. Address 15 is the interrupt mask. A read address sampled at a clock edge shows its bit on `rd_bit_o` from that edge on. Address 0 reads back the mode, address 15 reads back the mask, and any other address reads as 0.
- R3: In I/O mode, writes to addresses 1 to 14 change nothing, and reads of those addresses return 0.
- R4: In timer mode, writing address 14 launches the timer: the shadow value, including the bit just written, becomes both the launched value and the count. Writes to addresses 1 to 13 alone change neither the running count nor the period. A launched value of 0 stops the timer and never raises an interrupt.
- R5: With a non-zero launched value, the count falls by one every 30 clock cycles. The first decrement comes 30 cycles after the launch edge.
- R6: A decrement from a count of 1 instead reloads the launched value and sets the interrupt flag, so a launched value N gives an interrupt every 30*N cycles.
- R7: `irq_o` is high exactly when the flag is set and the mask is 1. The flag can be set while the mask is 0, and it shows on `irq_o` once the mask is set to 1.
- R8: The flag clears on any timer-mode write to addresses 1 to 14, and on a write of 0 to the mask. If the flag is set in the same cycle as one of these clears, the set wins.
- R9: Every write of 1 to address 0 copies the live count into the snapshot. Timer-mode reads of addresses 1 to 14 return snapshot bit k-1 until the next such capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Bit write strobe |
| wr_addr | input | 5 | Bit address of the write |
| wr_bit | input | 1 | Bit value written |
| rd_addr | input | 5 | Bit address of the read |
| rd_bit_o | output | 1 | Registered read data |
| irq_o | output | 1 | Masked interval interrupt |

## Verification
Directed patterns come first:
- A small launch value, which exercises period and reload.
- A launch value of one, the shortest period.
- A launch value of zero, which must stay idle.
- A large value read back through the snapshot, which shows the decrement rate apart from the reload.
- Writes made in I/O mode, which show gating apart from loading.
- Clears issued through the mask and through count-bit writes, including a flag set while masked.

After these, random single-bit writes and reads mostly load small values. This mixes launches, partial loads, mode changes and mask changes that fall at arbitrary prescaler phases. The random mix separates correct ordering of set against clear, and of launch against tick, from errors that show up only when those events coincide.

// File: rtl/sit_pkg.sv
package sit_pkg;

  typedef enum logic {
    MODE_IO  = 1'b0,
    MODE_CLK = 1'b1
  } sit_mode_e;

  // Address k (1..cnt_w) maps to count bit k-1.
  function automatic logic is_cnt_addr(input int unsigned addr, input int unsigned cnt_w);
    return (addr >= 1) && (addr <= cnt_w);
  endfunction

endpackage

// File: rtl/sit_bus_decode.sv
module sit_bus_decode #(
  parameter int ADDR_W = 5,
  parameter int CNT_W  = 14
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              clk_mode,
  output logic              mode_wr,
  output logic              mask_wr,
  output logic              cnt_wr,
  output logic              launch
);
  import sit_pkg::*;

  localparam int MASK_ADDR = CNT_W + 1;

  always_comb begin
    mode_wr = wr_en && (int'(wr_addr) == 0);
    mask_wr = wr_en && (int'(wr_addr) == MASK_ADDR);
    cnt_wr  = wr_en && clk_mode && is_cnt_addr(int'(wr_addr), CNT_W);
    launch  = cnt_wr && (int'(wr_addr) == CNT_W);
  end
endmodule

// File: rtl/sit_prescaler.sv
module sit_prescaler #(
  parameter int DIV = 30
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic restart,
  output logic tick
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] phase_q;

  always_ff @(posedge clk) begin
    if (rst || restart || !run) phase_q <= '0;
    else if (phase_q == LAST)   phase_q <= '0;
    else                        phase_q <= phase_q + 1'b1;
  end

  assign tick = run && !restart && (phase_q == LAST);

  // R5
  tick_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && DIV > 1) |=> !tick);
endmodule

// File: rtl/sit_decrementer.sv
module sit_decrementer #(
  parameter int CNT_W = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             tick,
  output logic [CNT_W-1:0] count_o,
  output logic             running_o,
  output logic             expire_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] reload_q, count_q;

  assign running_o = (reload_q != '0);
  assign expire_o  = tick && running_o && !load && (count_q == ONE);
  assign count_o   = count_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      reload_q <= '0;
      count_q  <= '0;
    end else if (load) begin
      reload_q <= load_val;
      count_q  <= load_val;
    end else if (tick && running_o) begin
      count_q <= (count_q == ONE) ? reload_q : count_q - 1'b1;
    end
  end

  // R4
  stopped_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (reload_q == '0) |-> (count_q == '0));
  // R6
  reload_chk: assert property (@(posedge clk) disable iff (rst)
    expire_o |=> (count_q == $past(reload_q)));
  // R5
  step_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && running_o && !load && count_q != ONE) |=> (count_q == $past(count_q) - 1'b1));
endmodule

// File: rtl/sit_irq.sv
module sit_irq (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  input  logic mask_wr,
  input  logic mask_val,
  output logic mask_o,
  output logic irq_o
);
  logic flag_q, mask_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
      mask_q <= 1'b0;
    end else begin
      if (mask_wr) mask_q <= mask_val;
      if (set_i)                                 flag_q <= 1'b1;
      else if (clr_i || (mask_wr && !mask_val))  flag_q <= 1'b0;
    end
  end

  assign mask_o = mask_q;
  assign irq_o  = flag_q && mask_q;

  // R8
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    set_i |=> (flag_q && (irq_o == mask_q)));
  // R8
  clear_chk: assert property (@(posedge clk) disable iff (rst)
    (!set_i && clr_i) |=> !irq_o);
endmodule

// File: rtl/serial_interval_timer.sv
module serial_interval_timer #(
  parameter int ADDR_W = 5,
  parameter int CNT_W  = 14,
  parameter int DIV    = 30
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              wr_bit,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_bit_o,
  output logic              irq_o
);
  import sit_pkg::*;

  localparam int MASK_ADDR = CNT_W + 1;

  sit_mode_e        mode_q;
  logic [CNT_W-1:0] shadow_q, shadow_nx, snap_q, count;
  logic             mode_wr, mask_wr, cnt_wr, launch;
  logic             tick, running, expire, mask;

  sit_bus_decode #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_dec (
    .wr_en(wr_en), .wr_addr(wr_addr), .clk_mode(mode_q == MODE_CLK),
    .mode_wr(mode_wr), .mask_wr(mask_wr), .cnt_wr(cnt_wr), .launch(launch)
  );

  always_comb begin
    shadow_nx = shadow_q;
    if (cnt_wr) shadow_nx[int'(wr_addr) - 1] = wr_bit;
  end

  sit_prescaler #(.DIV(DIV)) u_pre (
    .clk(clk), .rst(rst), .run(running), .restart(launch), .tick(tick)
  );

  sit_decrementer #(.CNT_W(CNT_W)) u_dcr (
    .clk(clk), .rst(rst), .load(launch), .load_val(shadow_nx), .tick(tick),
    .count_o(count), .running_o(running), .expire_o(expire)
  );

  sit_irq u_irq (
    .clk(clk), .rst(rst), .set_i(expire), .clr_i(cnt_wr),
    .mask_wr(mask_wr), .mask_val(wr_bit), .mask_o(mask), .irq_o(irq_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= MODE_IO;
      shadow_q <= '0;
      snap_q   <= '0;
      rd_bit_o <= 1'b0;
    end else begin
      shadow_q <= shadow_nx;
      if (mode_wr) mode_q <= wr_bit ? MODE_CLK : MODE_IO;
      if (mode_wr && wr_bit) snap_q <= count;
      if (int'(rd_addr) == 0)                       rd_bit_o <= (mode_q == MODE_CLK);
      else if (int'(rd_addr) == MASK_ADDR)          rd_bit_o <= mask;
      else if (is_cnt_addr(int'(rd_addr), CNT_W))   rd_bit_o <= (mode_q == MODE_CLK) && snap_q[int'(rd_addr) - 1];
      else                                          rd_bit_o <= 1'b0;
    end
  end

  // R9
  snap_capture_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_wr && wr_bit) |=> (snap_q == $past(count)));
  // R3
  io_mode_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_IO && !mode_wr) |=> $stable(shadow_q));
endmodule

// File: tb/serial_interval_timer_tb.sv
module serial_interval_timer_tb;
  localparam int CW = 14;
  localparam int DV = 30;

  logic clk = 1'b0, rst = 1'b1;
  logic wr_en = 1'b0, wr_bit = 1'b0;
  logic [4:0] wr_addr = '0, rd_addr = '0;
  logic rd_bit_o, irq_o;

  always #2 clk = ~clk;

  serial_interval_timer u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_bit(wr_bit),
    .rd_addr(rd_addr), .rd_bit_o(rd_bit_o), .irq_o(irq_o)
  );

  int checks = 0, fails = 0;
  string cur_req = "R1";

  // reference model state
  bit m_mode, m_mask, m_flag, m_rd;
  int m_shadow, m_reload, m_count, m_pre, m_snap;

  function automatic bit exp_rd(int a, bit mode, bit mask, int snap);
    if (a == 0) return mode;
    if (a == CW + 1) return mask;
    if (a >= 1 && a <= CW) return mode && snap[a-1];
    return 1'b0;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_mode = 0; m_mask = 0; m_flag = 0; m_rd = 0;
      m_shadow = 0; m_reload = 0; m_count = 0; m_pre = 0; m_snap = 0;
    end else begin
      automatic int a = int'(wr_addr);
      automatic bit cw = wr_en && m_mode && a >= 1 && a <= CW;
      automatic bit st = cw && a == CW;
      automatic bit run = m_reload != 0;
      automatic bit tk = run && !st && m_pre == DV - 1;
      automatic bit zr = tk && m_count == 1;
      automatic int old_count = m_count;
      m_rd = exp_rd(int'(rd_addr), m_mode, m_mask, m_snap);
      if (cw) m_shadow[a-1] = wr_bit;
      if (st || !run || m_pre == DV - 1) m_pre = 0; else m_pre = m_pre + 1;
      if (st) begin m_reload = m_shadow; m_count = m_shadow; end
      else if (tk) m_count = zr ? m_reload : m_count - 1;
      if (zr) m_flag = 1;
      else if (cw || (wr_en && a == CW + 1 && !wr_bit)) m_flag = 0;
      if (wr_en && a == CW + 1) m_mask = wr_bit;
      if (wr_en && a == 0) begin
        m_mode = wr_bit;
        if (wr_bit) m_snap = old_count;
      end
    end
  end

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) if (!rst) begin
    check(cur_req, "irq_o", int'(irq_o), int'(m_flag && m_mask));
    check(cur_req, "rd_bit_o", int'(rd_bit_o), int'(m_rd));
  end

  task automatic wr(int a, bit b);
    @(negedge clk); wr_en = 1; wr_addr = 5'(a); wr_bit = b;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic load(int v);
    for (int i = 1; i <= CW; i++) wr(i, v[i-1]);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic read_all();
    for (int i = 0; i <= CW + 2; i++) begin
      @(negedge clk); rd_addr = 5'(i);
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs quiet during and after reset
    check("R1", "irq_o in reset", int'(irq_o), 0);
    rst = 0;
    @(negedge clk);
    check("R1", "rd_bit_o after reset", int'(rd_bit_o), 0);
    cur_req = "R2"; read_all();

    cur_req = "R3"; load(5); wr(CW, 1); read_all(); idle(200);
    check("R3", "irq_o after I/O-mode load", int'(irq_o), 0);

    cur_req = "R6"; wr(0, 1); wr(CW + 1, 1); load(3); idle(30 * 3 * 3 + 10);
    cur_req = "R9"; wr(0, 1); read_all();

    cur_req = "R6"; load(1); idle(100);
    cur_req = "R4"; load(0); idle(400);
    check("R4", "irq_o with zero launch", int'(irq_o), 0);

    cur_req = "R5"; load(16'h3FFF); idle(30 * 5 + 3); wr(0, 1); read_all();
    idle(30 * 7); wr(0, 1); read_all();

    cur_req = "R7"; wr(CW + 1, 0); load(2); idle(30 * 2 + 5);
    wr(CW + 1, 1); idle(3);
    check("R7", "pending flag shown on unmask", int'(irq_o), 1);
    cur_req = "R8"; wr(3, 0); idle(3);
    check("R8", "count write clears flag", int'(irq_o), 0);
    idle(30 * 2); wr(CW + 1, 0); wr(CW + 1, 1); idle(2);
    check("R8", "mask clear drops flag", int'(irq_o), 0);

    cur_req = "RND";
    void'($urandom(32'd1234));
    for (int n = 0; n < 20000; n++) begin
      automatic int r = int'($urandom % 100);
      @(negedge clk);
      rd_addr = 5'($urandom % 17);
      if (r < 8) begin
        automatic int a = int'($urandom % 16);
        wr_en = 1; wr_addr = 5'(a);
        wr_bit = (a == 0 || a == CW + 1) ? ($urandom % 4 != 0) :
                 (a <= 3) ? 1'($urandom) : ($urandom % 12 == 0);
      end else wr_en = 0;
    end
    @(negedge clk); wr_en = 0;
    idle(5);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule